// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block decides which of eight DRAM rows a physical address falls into. Software programs one 8-bit boundary value per row. Each value is the cumulative top of memory up to and including that row, counted in 8 MB steps. A row begins where the closest lower row that holds memory ends, and row 0 begins at address zero. A row whose boundary repeats the previous one holds no memory. A zero boundary written after a nonzero one means the 2 GB top of memory.

Each address presented with a valid strobe is decoded in one registered stage. The result is a valid strobe, the index of the row that owns the address, and a flag for an address beyond installed memory. Two outputs follow the programmed boundaries continuously: a mask of the empty rows and the total installed size. Chip-select timing and DRAM command generation are handled elsewhere.

Top module: `row_boundary_decoder`

## Requirements
- R1: After reset every boundary register is 0, so all eight bits of `empty_rows` are 1, `mem_size` is 0 and `out_valid` is 0.
- R2: A cycle with `cfg_we` high writes `cfg_wdata` into the boundary register selected by `cfg_idx` (0 to 7 selects row 0 to 7). `empty_rows` and `mem_size` show the new value from the cycle after the write edge.
- R3: The upper limit of row i is its boundary value times 2^23 (8 MB units) and is exclusive. The base of row i is the effective limit of row i-1, and the base of row 0 is address 0.
- R4: A row whose effective limit equals its base is empty. Its bit in `empty_rows` (bit i for row i) is 1, and no address ever decodes to it.
- R5: A boundary value of 0 whose preceding effective limit is nonzero gives an effective limit of 0x8000_0000 (2 GB). A zero in row 0, or a zero after a zero limit, gives limit 0.
- R6: A decoded address that lies within base <= address < limit of some non-empty row returns the lowest such row index on `out_row`, with `out_oor` = 0.
- R7: An address matched by no row, which means at or above the highest limit, returns `out_oor` = 1 and `out_row` = 0.
- R8: `out_valid` is high exactly in the cycle after `in_valid` was high. The decode uses the boundary values held before that edge, so a write on the same edge does not affect it.
- R9: `mem_size` equals the highest effective limit over all eight rows.
- R10: An address equal to a row's limit does not belong to that row. It goes to the next non-empty row above, or is out of range if no such row exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_idx | input | 3 | Row whose boundary register is written |
| cfg_wdata | input | 8 | Boundary value in 8 MB units |
| in_valid | input | 1 | Address to decode is present |
| in_addr | input | 32 | Physical address to decode |
| out_valid | output | 1 | Decode result valid (one cycle after `in_valid`) |
| out_row | output | 3 | Row owning the address (0 when out of range) |
| out_oor | output | 1 | Address is beyond installed memory |
| empty_rows | output | 8 | Bit i set when row i holds no memory |
| mem_size | output | 32 | Highest effective row limit in bytes |

## Verification
The hardest cases to reach are the ones where the 2 GB substitution meets the empty-row rule. Examples are a zero boundary that follows a nonzero one, then further zeros that must read as empty, and leading rows that are empty because they are zero before any memory. Random monotonic boundary sets are built from random steps, repeated values, runs of leading zeros and a random point where the 2 GB zero is inserted. Probe addresses are drawn at each limit and one byte below it, as well as inside rows and above the top. Directed cases add the full 2 GB map with probes at 0x7FFF_FFFF and 0x8000_0000, and a boundary write on the same edge as a decode.

// File: rtl/rbd_pkg.sv
// Package: default sizing for the row boundary decoder.
// Assumes: boundary width plus unit shift leaves one spare address bit
// for the top-of-memory code.
package rbd_pkg;
    localparam int RBD_ROWS       = 8;
    localparam int RBD_BND_W      = 8;
    localparam int RBD_UNIT_SHIFT = 23;
    localparam int RBD_ADDR_W     = 32;
endpackage

// File: rtl/rbd_bound_regs.sv
// Module: boundary register file, one register per row.
// Assumes: a single write port; writes take effect after the clock edge.
module rbd_bound_regs #(
    parameter int ROWS  = rbd_pkg::RBD_ROWS,
    parameter int BND_W = rbd_pkg::RBD_BND_W,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BND_W-1:0]           wr_data,
    output logic [ROWS-1:0][BND_W-1:0] bnd_q
);
    // Store a boundary value on each write; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_q <= '0;
        end else if (wr_en) begin
            bnd_q[wr_idx] <= wr_data;
        end
    end

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bnd_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rbd_limit_chain.sv
// Module: turns cumulative boundary codes into byte limits, row bases,
// an empty-row mask and the installed size.
// Assumes: purely combinational from the register file; the clock is
// used only by the checks.
module rbd_limit_chain #(
    parameter int ROWS       = rbd_pkg::RBD_ROWS,
    parameter int BND_W      = rbd_pkg::RBD_BND_W,
    parameter int UNIT_SHIFT = rbd_pkg::RBD_UNIT_SHIFT,
    parameter int ADDR_W     = rbd_pkg::RBD_ADDR_W,
    localparam logic [ADDR_W-1:0] TOP_LIM = ADDR_W'(1) << (BND_W + UNIT_SHIFT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ROWS-1:0][BND_W-1:0]  bnd_q,
    output logic [ROWS-1:0][ADDR_W-1:0] row_base,
    output logic [ROWS-1:0][ADDR_W-1:0] row_lim,
    output logic [ROWS-1:0]             row_empty,
    output logic [ADDR_W-1:0]           total_size
);
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        logic [ADDR_W-1:0] raw;
        // Scale the boundary code to a byte address.
        always_comb raw = ADDR_W'(bnd_q[i]) << UNIT_SHIFT;
        if (i == 0) begin : g_first
            // Row 0 starts at zero and has no top-of-memory substitution.
            always_comb row_base[i] = '0;
        end else begin : g_next
            // Later rows start at the previous effective limit.
            always_comb row_base[i] = row_lim[i-1];
        end
        // Zero after nonzero means top of memory; equal limits mean empty.
        always_comb begin
            row_lim[i]   = (row_base[i] != '0 && raw == '0) ? TOP_LIM : raw;
            row_empty[i] = (row_lim[i] == row_base[i]);
        end
    end

    // Installed size is the largest effective limit.
    always_comb begin
        total_size = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (row_lim[i] > total_size) total_size = row_lim[i];
        end
    end

    // R5
    first_zero_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_q[0] == '0) |-> row_empty[0]);
    // R9
    size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_size <= TOP_LIM);
    // R4
    zero_size_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total_size == '0) |-> (&row_empty));
endmodule

// File: rtl/rbd_match_stage.sv
// Module: priority row match and the registered result stage.
// Assumes: boundaries are non-decreasing; otherwise matches are undefined.
module rbd_match_stage #(
    parameter int ROWS   = rbd_pkg::RBD_ROWS,
    parameter int ADDR_W = rbd_pkg::RBD_ADDR_W,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [ROWS-1:0][ADDR_W-1:0] row_base,
    input  logic [ROWS-1:0][ADDR_W-1:0] row_lim,
    input  logic [ROWS-1:0]             row_empty,
    output logic                        out_valid,
    output logic [IDX_W-1:0]            out_row,
    output logic                        out_oor
);
    logic [ROWS-1:0]  hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_row;

    // Per-row window test; empty rows never hit.
    for (genvar i = 0; i < ROWS; i++) begin : g_hit
        always_comb hit_vec[i] = !row_empty[i] && (in_addr >= row_base[i])
                                 && (in_addr < row_lim[i]);
    end

    // Lowest-numbered hitting row wins; scan from the top down.
    always_comb begin
        any_hit = 1'b0;
        hit_row = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_row = IDX_W'(i);
            end
        end
    end

    // Register the decode result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_oor   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_row <= hit_row;
                out_oor <= !any_hit;
            end
        end
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    oor_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_oor) |-> (out_row == '0));
endmodule

// File: rtl/row_boundary_decoder.sv
// Module: top of the DRAM row boundary decoder.
// Assumes: software programs non-decreasing cumulative boundaries.
module row_boundary_decoder #(
    parameter int ROWS       = rbd_pkg::RBD_ROWS,
    parameter int BND_W      = rbd_pkg::RBD_BND_W,
    parameter int UNIT_SHIFT = rbd_pkg::RBD_UNIT_SHIFT,
    parameter int ADDR_W     = rbd_pkg::RBD_ADDR_W,
    localparam int IDX_W     = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BND_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_row,
    output logic              out_oor,
    output logic [ROWS-1:0]   empty_rows,
    output logic [ADDR_W-1:0] mem_size
);
    logic [ROWS-1:0][BND_W-1:0]  bnd_q;
    logic [ROWS-1:0][ADDR_W-1:0] row_base;
    logic [ROWS-1:0][ADDR_W-1:0] row_lim;

    rbd_bound_regs #(.ROWS(ROWS), .BND_W(BND_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
        .wr_data(cfg_wdata), .bnd_q(bnd_q)
    );

    rbd_limit_chain #(.ROWS(ROWS), .BND_W(BND_W), .UNIT_SHIFT(UNIT_SHIFT),
                      .ADDR_W(ADDR_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .bnd_q(bnd_q), .row_base(row_base),
        .row_lim(row_lim), .row_empty(empty_rows), .total_size(mem_size)
    );

    rbd_match_stage #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .row_base(row_base), .row_lim(row_lim), .row_empty(empty_rows),
        .out_valid(out_valid), .out_row(out_row), .out_oor(out_oor)
    );
endmodule

// File: tb/tb_row_boundary_decoder.sv
module tb_row_boundary_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic        in_valid;
    logic [31:0] in_addr;
    logic        out_valid;
    logic [2:0]  out_row;
    logic        out_oor;
    logic [7:0]  empty_rows;
    logic [31:0] mem_size;

    always #5 clk = ~clk;

    row_boundary_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_row(out_row), .out_oor(out_oor),
        .empty_rows(empty_rows), .mem_size(mem_size)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0]  m_bnd [8];
    logic [31:0] m_lim [8];
    logic [7:0]  m_emp;

    // Bench model of effective limits per R3, R4, R5.
    task automatic model_update();
        logic [31:0] prev = 32'h0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lim = {m_bnd[i], 23'h0} >> 0;
            lim = 32'(m_bnd[i]) * 32'h0080_0000;
            if (prev != 0 && lim == 0) lim = 32'h8000_0000;
            m_lim[i] = lim;
            m_emp[i] = (lim == prev);
            prev = lim;
        end
    endtask

    function automatic logic [31:0] exp_size();
        logic [31:0] s = 0;
        for (int i = 0; i < 8; i++) if (m_lim[i] > s) s = m_lim[i];
        return s;
    endfunction

    // Lowest non-empty row containing the address (R6, R7, R10).
    function automatic logic [3:0] exp_decode(input logic [31:0] a);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] b = (i == 0) ? 32'h0 : m_lim[i-1];
            if (!m_emp[i] && a >= b && a < m_lim[i]) return {1'b0, 3'(i)};
        end
        return 4'b1000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        m_bnd[idx] = val;
        model_update();
    endtask

    task automatic check_cfg(input string tag);
        check({tag, " R4 empty_rows"}, 32'(empty_rows), 32'(m_emp));
        check({tag, " R9 mem_size"}, mem_size, exp_size());
    endtask

    task automatic load(input logic [7:0] v [8], input string tag);
        for (int i = 0; i < 8; i++) wr(i, v[i]);
        check_cfg({tag, " R2 R3"});
    endtask

    task automatic probe(input logic [31:0] a, input string tag);
        logic [3:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        e = exp_decode(a);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R8 out_valid"}, 32'(out_valid), 32'h1);
        check({tag, " R6 out_row"}, 32'(out_row), 32'(e[2:0]));
        check({tag, " R7 out_oor"}, 32'(out_oor), 32'(e[3]));
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cfg [8];
        logic [31:0] a;
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_addr = '0;
        for (int i = 0; i < 8; i++) m_bnd[i] = 8'h0;
        model_update();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty_rows", 32'(empty_rows), 32'hFF);
        check("R1 mem_size", mem_size, 32'h0);
        check("R1 out_valid", 32'(out_valid), 32'h0);
        probe(32'h0, "R1 R7 empty map");

        // Directed: repeats, 2 GB top, trailing zeros.
        cfg = '{8'd1, 8'd1, 8'd3, 8'd3, 8'd4, 8'd0, 8'd0, 8'd0};
        load(cfg, "dir2g R5");
        check("R5 mem_size 2GB", mem_size, 32'h8000_0000);
        check("R4 R5 empty mask", 32'(empty_rows), 32'hCA);
        probe(32'h0000_0000, "dir2g R3 base0");
        probe(32'h007F_FFFF, "dir2g R3 below limit");
        probe(32'h0080_0000, "dir2g R10 at limit skips empty row1");
        probe(32'h017F_FFFF, "dir2g R6 row2 top");
        probe(32'h0180_0000, "dir2g R10 row4 start");
        probe(32'h0200_0000, "dir2g R5 row5 start");
        probe(32'h7FFF_FFFF, "dir2g R5 row5 top");
        probe(32'h8000_0000, "dir2g R7 at 2GB");
        probe(32'hFFFF_FFFF, "dir2g R7 max addr");

        // Directed: leading empty rows, last row full range below top.
        cfg = '{8'd0, 8'd0, 8'd0, 8'd10, 8'd10, 8'd20, 8'd20, 8'd255};
        load(cfg, "lead R4");
        probe(32'h0000_0000, "lead R4 skips leading empties");
        probe(32'h04FF_FFFF, "lead R6 row3");
        probe(32'h0A00_0000, "lead R10 row7 start");
        probe(32'h7F80_0000, "lead R7 at top");

        // R8: write on the same edge as a decode uses the old value.
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h7F00_0000;
        cfg_we = 1'b1; cfg_idx = 3'd7; cfg_wdata = 8'd200;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        check("R8 old boundary row", 32'(out_row), 32'd7);
        check("R8 old boundary oor", 32'(out_oor), 32'd0);
        m_bnd[7] = 8'd200; model_update();
        check_cfg("R2 after write");
        @(negedge clk);
        check("R8 out_valid drops", 32'(out_valid), 32'h0);
        probe(32'h7F00_0000, "R2 R7 new boundary");

        // Random monotonic maps with directed-style probe points.
        for (int c = 0; c < 60; c++) begin
            logic [8:0] cur = 0;
            bit topped = 0;
            int lead = $urandom % 3;
            for (int i = 0; i < 8; i++) begin
                int r = $urandom % 5;
                if (topped) cfg[i] = 8'd0;
                else if (i < lead) cfg[i] = 8'd0;
                else if (r == 0) cfg[i] = cur[7:0];
                else if (r == 1 && cur != 0 && ($urandom % 3 == 0)) begin
                    cfg[i] = 8'd0; topped = 1;
                end else begin
                    cur = cur + 9'(1 + $urandom % 50);
                    if (cur > 255) cur = 255;
                    cfg[i] = cur[7:0];
                end
            end
            load(cfg, "rand");
            for (int p = 0; p < 12; p++) begin
                int k = $urandom % 8;
                case ($urandom % 5)
                    0: a = m_lim[k];
                    1: a = m_lim[k] - 32'd1;
                    2: a = (exp_size() == 0) ? 32'h0 : $urandom % exp_size();
                    3: a = exp_size() + ($urandom % 32'h0100_0000);
                    default: a = $urandom;
                endcase
                probe(a, "rand R6 R7 R10");
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule